// File: doc/BRIEF.md
# Lockable Configuration Store Controller

This block owns the configuration image of a programmable device, kept as an array of words in flip-flops, together with a one-bit lock and a 64-bit identification word. It is driven through a single command port with a valid/ready handshake. A command can wipe the whole store, OR new bits into one word, read one word back, raise the lock, or write or read one 16-bit slice of the identification word.

Once the lock is up, the image is sealed. Reads of the array come back as zeros with an error flag, and writes are refused. Only a full wipe drops the lock again, and the wipe also clears the image and the identification word. The identification word stays readable while sealed, so a locked part can still report which pattern or revision it holds. A wipe keeps the controller busy for a fixed number of cycles, and no command is taken during that time.

Top module: `cfgmem_guard`

## Requirements
- R1: After reset, busy and locked are 0, rsp_valid is 0, every array word reads as 0 and every signature slice reads as 0.
- R2: cmd_ready equals the inverse of busy. A command other than wipe that is accepted on a clock edge gives rsp_valid high for exactly the one cycle that follows that edge.
- R3: Op code 1 (program) replaces the word at cmd_addr with the bitwise OR of the stored word and cmd_wdata. Op code 2 (verify) returns the stored word on rsp_rdata with rsp_err 0 while unlocked.
- R4: Op code 0 (wipe) sets every array word to 0, sets all signature slices to 0 and clears the lock. Busy is high for ERASE_CYC cycles, starting right after the accepting edge. rsp_valid with rsp_err 0 appears on the edge where busy falls, and no command is accepted while busy.
- R5: Op code 3 (lock) sets locked with rsp_err 0. Program with cmd_lock 1 while unlocked stores the word and then sets locked.
- R6: While locked, verify answers rsp_err 1 with rsp_rdata 0, and program answers rsp_err 1.
- R7: Op code 4 writes cmd_wdata into signature slice cmd_addr (slice k is bits 16k+15..16k of the word, for k from 0 to 3). Op code 5 returns that slice. The read is allowed while locked, and the write is refused with rsp_err 1 while locked.
- R8: A signature access with cmd_addr of 4 or more, or an op code of 6 or 7, answers rsp_err 1 with rsp_rdata 0.
- R9: Once set, locked stays 1 through every command other than wipe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 3 | Operation code |
| cmd_addr | input | ADDR_W (4) | Word address or signature slice index |
| cmd_wdata | input | DATA_W (16) | Write data |
| cmd_lock | input | 1 | With program: lock after storing |
| rsp_valid | output | 1 | Response pulse |
| rsp_err | output | 1 | Command refused |
| rsp_rdata | output | DATA_W (16) | Read data |
| busy | output | 1 | Wipe in progress |
| locked | output | 1 | Lock state |

## Verification
The bench programs every word twice with overlapping patterns. A design that overwrote instead of ORing would lose the first pattern's bits. It then locks and sweeps verify over all addresses, where leaked array data or a missing error flag would show at once. The signature is read in every slice both before and after locking, and a design that sealed the signature too would return errors there. The wipe length is counted cycle by cycle while a stray command is held, which catches an off-by-one busy window or a command slipping in during the wipe. Out-of-range slice indices and the two unused op codes are swept for error responses.

// File: rtl/cfgmem_pkg.sv
package cfgmem_pkg;
   typedef enum logic [2:0] {
      OP_WIPE   = 3'd0,
      OP_PROG   = 3'd1,
      OP_VERIFY = 3'd2,
      OP_LOCK   = 3'd3,
      OP_SIGWR  = 3'd4,
      OP_SIGRD  = 3'd5
   } cmd_op_e;
endpackage

// File: rtl/cfgmem_store.sv
module cfgmem_store #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   initial begin : p_param_chk
      assert (ADDR_W >= 1 && DATA_W >= 1) else $error("cfgmem_store: bad widths");
   end

   for (genvar w = 0; w < DEPTH; w++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mem[w] <= '0;
         else if (clr)
            mem[w] <= '0;
         else if (we && addr == ADDR_W'(w))
            mem[w] <= mem[w] | wdata;
      end

      // R3: without a wipe, a set bit never falls back
      a_r3_bits_only_rise: assert property (@(posedge clk) disable iff (!rst_n)
         !clr |=> ((mem[w] & $past(mem[w])) == $past(mem[w])));

      // R4: a wipe leaves the word at zero
      a_r4_word_cleared: assert property (@(posedge clk) disable iff (!rst_n)
         clr |=> (mem[w] == '0));
   end

   assign rdata = mem[addr];
endmodule

// File: rtl/cfgmem_sig.sv
module cfgmem_sig #(
   parameter int SIG_W  = 64,
   parameter int DATA_W = 16,
   parameter int SEL_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              we,
   input  logic [SEL_W-1:0]  sel,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] part_q
);
   localparam int PARTS = SIG_W / DATA_W;

   logic [DATA_W-1:0] part [PARTS];

   initial begin : p_param_chk
      assert (SIG_W % DATA_W == 0) else $error("cfgmem_sig: SIG_W not a multiple of DATA_W");
      assert ((1 << SEL_W) >= PARTS) else $error("cfgmem_sig: SEL_W too narrow");
   end

   for (genvar k = 0; k < PARTS; k++) begin : g_part
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            part[k] <= '0;
         else if (clr)
            part[k] <= '0;
         else if (we && sel == SEL_W'(k))
            part[k] <= wdata;
      end

      // R4: wipe also clears every signature slice
      a_r4_sig_cleared: assert property (@(posedge clk) disable iff (!rst_n)
         clr |=> (part[k] == '0));
   end

   always_comb begin
      part_q = '0;
      for (int k = 0; k < PARTS; k++)
         if (sel == SEL_W'(k)) part_q = part[k];
   end
endmodule

// File: rtl/cfgmem_ctrl.sv
module cfgmem_ctrl
   import cfgmem_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int DATA_W    = 16,
   parameter int SIG_W     = 64,
   parameter int ERASE_CYC = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [2:0]        cmd_op,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic              cmd_lock,
   input  logic [DATA_W-1:0] arr_rdata,
   input  logic [DATA_W-1:0] sig_rdata,
   output logic              clr,
   output logic              prog_we,
   output logic              sig_we,
   output logic              rsp_valid,
   output logic              rsp_err,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              busy,
   output logic              locked
);
   localparam int PARTS = SIG_W / DATA_W;
   localparam int CNT_W = $clog2(ERASE_CYC + 1);

   initial begin : p_param_chk
      assert (ERASE_CYC >= 1) else $error("cfgmem_ctrl: ERASE_CYC must be at least 1");
      assert (PARTS <= (1 << ADDR_W)) else $error("cfgmem_ctrl: signature slices exceed address space");
   end

   logic             acc;
   logic             err_c;
   logic             set_lock_c;
   logic             sig_in_rng;
   logic [DATA_W-1:0] rd_c;
   logic [CNT_W-1:0] cnt;
   cmd_op_e          op;

   assign op         = cmd_op_e'(cmd_op);
   assign cmd_ready  = !busy;
   assign acc        = cmd_valid && !busy;
   assign sig_in_rng = (32'(cmd_addr) < PARTS);

   always_comb begin
      err_c      = 1'b0;
      rd_c       = '0;
      set_lock_c = 1'b0;
      prog_we    = 1'b0;
      sig_we     = 1'b0;
      clr        = 1'b0;
      if (acc) begin
         case (cmd_op)
            3'd0: clr = 1'b1;
            3'd1: begin
               if (locked) err_c = 1'b1;
               else begin
                  prog_we    = 1'b1;
                  set_lock_c = cmd_lock;
               end
            end
            3'd2: begin
               if (locked) err_c = 1'b1;
               else rd_c = arr_rdata;
            end
            3'd3: set_lock_c = 1'b1;
            3'd4: begin
               if (locked || !sig_in_rng) err_c = 1'b1;
               else sig_we = 1'b1;
            end
            3'd5: begin
               if (!sig_in_rng) err_c = 1'b1;
               else rd_c = sig_rdata;
            end
            default: err_c = 1'b1;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (clr) begin
         busy <= 1'b1;
         cnt  <= CNT_W'(ERASE_CYC - 1);
      end else if (busy) begin
         if (cnt == '0) busy <= 1'b0;
         else cnt <= cnt - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         locked <= 1'b0;
      else if (clr)
         locked <= 1'b0;
      else if (set_lock_c)
         locked <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= 1'b0;
         if (acc && !clr) begin
            rsp_valid <= 1'b1;
            rsp_err   <= err_c;
            rsp_rdata <= rd_c;
         end else if (busy && cnt == '0) begin
            rsp_valid <= 1'b1;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
         end
      end
   end

   // R6: a sealed verify answers with an error and no data
   a_r6_verify_refused: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && op == OP_VERIFY && locked) |=> (rsp_valid && rsp_err && rsp_rdata == '0));

   // R9: the lock only drops through a wipe
   a_r9_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && !(acc && op == OP_WIPE)) |=> locked);

   // R4: accepting a wipe starts the busy window and unlocks
   a_r4_wipe_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && op == OP_WIPE) |=> (busy && !locked));

   // R2: no response is given while a wipe is still running
   a_r2_rsp_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !busy);

   // R7: an in-range signature read is served even when sealed
   a_r7_sig_read_open: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && op == OP_SIGRD && sig_in_rng) |=> (rsp_valid && !rsp_err));
endmodule

// File: rtl/cfgmem_guard.sv
module cfgmem_guard #(
   parameter int ADDR_W    = 4,
   parameter int DATA_W    = 16,
   parameter int SIG_W     = 64,
   parameter int ERASE_CYC = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [2:0]        cmd_op,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] cmd_wdata,
   input  logic              cmd_lock,
   output logic              rsp_valid,
   output logic              rsp_err,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              busy,
   output logic              locked
);
   localparam int PARTS = SIG_W / DATA_W;
   localparam int SEL_W = (PARTS > 1) ? $clog2(PARTS) : 1;

   logic              clr;
   logic              prog_we;
   logic              sig_we;
   logic [DATA_W-1:0] arr_rdata;
   logic [DATA_W-1:0] sig_rdata;

   cfgmem_ctrl #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIG_W(SIG_W), .ERASE_CYC(ERASE_CYC)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
      .cmd_addr(cmd_addr), .cmd_lock(cmd_lock),
      .arr_rdata(arr_rdata), .sig_rdata(sig_rdata),
      .clr(clr), .prog_we(prog_we), .sig_we(sig_we),
      .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
      .busy(busy), .locked(locked)
   );

   cfgmem_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
      .clk(clk), .rst_n(rst_n), .clr(clr), .we(prog_we),
      .addr(cmd_addr), .wdata(cmd_wdata), .rdata(arr_rdata)
   );

   cfgmem_sig #(.SIG_W(SIG_W), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_sig (
      .clk(clk), .rst_n(rst_n), .clr(clr), .we(sig_we),
      .sel(cmd_addr[SEL_W-1:0]), .wdata(cmd_wdata), .part_q(sig_rdata)
   );
endmodule

// File: tb/cfgmem_guard_test.sv
`timescale 1ns/1ps
module cfgmem_guard_test;
   localparam int ECYC = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic [2:0]  cmd_op = 3'd0;
   logic [3:0]  cmd_addr = 4'd0;
   logic [15:0] cmd_wdata = 16'd0;
   logic        cmd_lock = 1'b0;
   logic        rsp_valid, rsp_err, busy, locked;
   logic [15:0] rsp_rdata;

   int n_cmp = 0;
   int n_bad = 0;
   logic        got_v, got_e;
   logic [15:0] got_d;

   always #10 clk = ~clk;

   cfgmem_guard #(.ADDR_W(4), .DATA_W(16), .SIG_W(64), .ERASE_CYC(ECYC)) uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_lock(cmd_lock),
      .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
      .busy(busy), .locked(locked)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic issue(input logic [2:0] op, input logic [3:0] a, input logic [15:0] d, input logic lk);
      @(negedge clk);
      while (!cmd_ready) @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = d; cmd_lock = lk;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_lock = 1'b0;
      got_v = rsp_valid; got_e = rsp_err; got_d = rsp_rdata;
   endtask

   function automatic logic [15:0] pat_a(input int a);
      return 16'h0F0F ^ 16'(a * 16'h1111);
   endfunction
   function automatic logic [15:0] pat_b(input int a);
      return 16'h8001 | 16'(a << 4);
   endfunction
   function automatic logic [15:0] pat_s(input int k);
      return 16'hA5C3 ^ 16'(k * 16'h0101);
   endfunction

   task automatic wipe_and_count();
      int n;
      issue(3'd0, 4'd0, 16'd0, 1'b0);
      n = 0;
      while (busy) begin
         n++;
         if (n == 1) begin
            chk(cmd_ready == 1'b0, "R4 ready low during wipe", 32'(cmd_ready), 0);
            cmd_valid = 1'b1; cmd_op = 3'd2;
         end
         if (n == 2) cmd_valid = 1'b0;
         @(negedge clk);
         if (n > 100) break;
      end
      chk(n == ECYC, "R4 busy length", n, ECYC);
      chk(rsp_valid && !rsp_err, "R4 wipe response", {rsp_valid, rsp_err}, 2'b10);
      @(negedge clk);
      chk(!rsp_valid, "R4 stray command not taken", 32'(rsp_valid), 0);
   endtask

   initial begin : watchdog
      #(20 * 150000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !locked && !rsp_valid, "R1 reset flags", {busy, locked, rsp_valid}, 0);
      chk(cmd_ready == !busy, "R2 ready idle", 32'(cmd_ready), 1);

      for (int a = 0; a < 16; a++) begin
         issue(3'd2, 4'(a), 16'd0, 1'b0);
         chk(got_v && !got_e && got_d == 16'd0, "R1 word zero", got_d, 0);
      end
      for (int k = 0; k < 4; k++) begin
         issue(3'd5, 4'(k), 16'd0, 1'b0);
         chk(got_v && !got_e && got_d == 16'd0, "R1 slice zero", got_d, 0);
      end

      issue(3'd2, 4'd3, 16'd0, 1'b0);
      @(negedge clk);
      chk(!rsp_valid, "R2 single cycle pulse", 32'(rsp_valid), 0);

      for (int a = 0; a < 16; a++) issue(3'd1, 4'(a), pat_a(a), 1'b0);
      for (int a = 0; a < 16; a++) begin
         issue(3'd2, 4'(a), 16'd0, 1'b0);
         chk(got_v && !got_e && got_d == pat_a(a), "R3 first program", got_d, pat_a(a));
      end
      for (int a = 0; a < 16; a++) begin
         issue(3'd1, 4'(a), pat_b(a), 1'b0);
         chk(got_v && !got_e, "R3 program response", {got_v, got_e}, 2'b10);
      end
      for (int a = 0; a < 16; a++) begin
         issue(3'd2, 4'(a), 16'd0, 1'b0);
         chk(got_d == (pat_a(a) | pat_b(a)), "R3 OR accumulate", got_d, pat_a(a) | pat_b(a));
      end

      for (int k = 0; k < 4; k++) issue(3'd4, 4'(k), pat_s(k), 1'b0);
      for (int k = 0; k < 4; k++) begin
         issue(3'd5, 4'(k), 16'd0, 1'b0);
         chk(got_v && !got_e && got_d == pat_s(k), "R7 slice readback", got_d, pat_s(k));
      end
      for (int a = 4; a < 16; a++) begin
         issue(3'd5, 4'(a), 16'd0, 1'b0);
         chk(got_e && got_d == 16'd0, "R8 slice index range read", {got_e, got_d}, 17'h10000);
         issue(3'd4, 4'(a), 16'hFFFF, 1'b0);
         chk(got_e, "R8 slice index range write", 32'(got_e), 1);
      end
      for (int op = 6; op < 8; op++) begin
         issue(3'(op), 4'd1, 16'hFFFF, 1'b0);
         chk(got_v && got_e && got_d == 16'd0, "R8 unused op", {got_e, got_d}, 17'h10000);
      end

      issue(3'd3, 4'd0, 16'd0, 1'b0);
      chk(!got_e && locked, "R5 lock command", {got_e, locked}, 2'b01);
      for (int a = 0; a < 16; a++) begin
         issue(3'd2, 4'(a), 16'd0, 1'b0);
         chk(got_e && got_d == 16'd0, "R6 sealed verify", {got_e, got_d}, 17'h10000);
      end
      issue(3'd1, 4'd2, 16'hFFFF, 1'b0);
      chk(got_e, "R6 sealed program", 32'(got_e), 1);
      for (int k = 0; k < 4; k++) begin
         issue(3'd5, 4'(k), 16'd0, 1'b0);
         chk(!got_e && got_d == pat_s(k), "R7 slice read while sealed", got_d, pat_s(k));
      end
      issue(3'd4, 4'd1, 16'h1234, 1'b0);
      chk(got_e, "R7 slice write sealed", 32'(got_e), 1);
      issue(3'd5, 4'd1, 16'd0, 1'b0);
      chk(got_d == pat_s(1), "R7 sealed write had no effect", got_d, pat_s(1));
      issue(3'd3, 4'd0, 16'd0, 1'b0);
      issue(3'd7, 4'd0, 16'd0, 1'b0);
      chk(locked, "R9 lock holds", 32'(locked), 1);

      wipe_and_count();
      chk(!locked, "R4 wipe unlocks", 32'(locked), 0);
      for (int a = 0; a < 16; a++) begin
         issue(3'd2, 4'(a), 16'd0, 1'b0);
         chk(!got_e && got_d == 16'd0, "R4 word wiped", got_d, 0);
      end
      for (int k = 0; k < 4; k++) begin
         issue(3'd5, 4'(k), 16'd0, 1'b0);
         chk(got_d == 16'd0, "R4 slice wiped", got_d, 0);
      end

      issue(3'd1, 4'd9, 16'h5A5A, 1'b1);
      chk(!got_e && locked, "R5 program then lock", {got_e, locked}, 2'b01);
      issue(3'd2, 4'd9, 16'd0, 1'b0);
      chk(got_e && got_d == 16'd0, "R6 verify after program-lock", {got_e, got_d}, 17'h10000);
      wipe_and_count();
      issue(3'd2, 4'd9, 16'd0, 1'b0);
      chk(!got_e && got_d == 16'd0, "R4 program-lock word wiped", got_d, 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule